// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDRAM interface. It takes the memory from power-up to an operational state. After reset it drives a no-operation command with clock enable and the byte masks high, and it waits out the required power-up pause. It then closes every bank with one precharge-all command and runs a train of auto refresh commands. Last, it loads the mode register with the burst length, burst type and CAS latency taken from configuration inputs. Once the mode-set recovery time has passed, it raises a done flag. The flag tells the normal command scheduler that it may take over the pins.

The delays are given in nanoseconds and converted to clock counts from the clock period parameter, rounding up. Each gap between two commands is at least two clocks. Between commands, and after the done flag, the pins carry the no-operation code. The configuration inputs reach the address bus only in the mode-set cycle.

Top module: `sdram_boot_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, the command pins carry NOP (`cs_n`=0, `ras_n`=1, `cas_n`=1, `we_n`=1), `sd_cke` is 1, every `sd_dqm` bit is 1, `sd_ba` and `sd_addr` are 0, and `init_done` is 0.
- R2: Counting the cycle in which reset is released as cycle 0, the pins stay at NOP, with CKE and DQM high, for P cycles. P = ceil(PAUSE_NS*1000/CLK_PERIOD_PS), with a minimum of 1.
- R3: In cycle P the block issues precharge-all: `cs_n`=0, `ras_n`=0, `cas_n`=1, `we_n`=0, with only `sd_addr` bit 10 set and bank 0.
- R4: The first auto refresh comes Gp cycles after the precharge. Gp = max(2, ceil(TRP_NS*1000/CLK_PERIOD_PS)).
- R5: Exactly REF_COUNT (default 8) auto refresh commands are issued (`cs_n`=0, `ras_n`=0, `cas_n`=0, `we_n`=1, address 0). Consecutive refreshes are Gc = max(2, ceil(TRC_NS*1000/CLK_PERIOD_PS)) cycles apart.
- R6: Gc cycles after the last refresh, the block issues mode register set (all four command pins low, bank 0). The address carries burst code in bits 2:0, interleave in bit 3, CAS latency in bits 6:4 (3'b011 when `cfg_cas3`=1, else 3'b010), and zeros above.
- R7: `init_done` rises exactly Gr = max(2, TRSC_CYC) cycles after the mode register set. Every cycle between commands carries NOP.
- R8: Once `init_done` is high it stays high until reset. The pins then hold NOP, with CKE high and all DQM bits low.
- R9: Asserting `rst_n` at any point, including in the middle of the refresh train, returns the outputs to the R1 state and restarts the whole sequence from the pause.
- R10: The configuration inputs have no effect on any output except in the mode register set cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_burst_code | input | 3 | Burst length code placed in the mode word |
| cfg_interleave | input | 1 | 1 selects interleaved burst order |
| cfg_cas3 | input | 1 | 1 selects CAS latency 3, 0 selects 2 |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank select |
| sd_addr | output | ADDR_W | Address bus (A10 and mode word) |
| sd_dqm | output | DQM_W | Byte masks |
| init_done | output | 1 | High once initialization has completed |

## Verification
The hardest situation to reach from the ports is a reset that arrives partway through the sequence. Examples are a reset inside the refresh train or in the mode-set cycle, when the refresh tally and the shared wait counter both hold live values. The stimulus aborts one pass at a random cycle between the precharge and just past completion, then checks that the next pass restarts cleanly and keeps its exact schedule. The configuration inputs are scrambled from $urandom on every cycle except the mode-set cycle. Any leak of configuration onto the address bus, or a mode word latched at the wrong time, therefore shows up directly.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_PRE = 2'd1,
    CMD_REF = 2'd2,
    CMD_MRS = 2'd3
  } boot_cmd_e;

  // Round a nanosecond delay up to whole clocks.
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned period_ps);
    return (ns * 1000 + period_ps - 1) / period_ps;
  endfunction

  // A command-to-command gap never drops below two clocks.
  function automatic int unsigned gap_cycles(input int unsigned c);
    return (c < 2) ? 2 : c;
  endfunction

  // Mode word: [2:0] burst code, [3] interleave, [6:4] CAS latency, [9:7] zero.
  function automatic logic [9:0] mode_word(input logic [2:0] burst,
                                           input logic       inter,
                                           input logic       cas3);
    logic [2:0] cl;
    cl = cas3 ? 3'd3 : 3'd2;
    return {3'b000, cl, inter, burst};
  endfunction

endpackage

// File: rtl/sdram_boot_timer.sv
module sdram_boot_timer #(
  parameter int W       = 8,
  parameter int RST_VAL = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= W'(RST_VAL);
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end

  assign expired = (cnt == '0);

  // R4 R5 R7: every wait runs down one step per clock
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - W'(1)));

endmodule

// File: rtl/sdram_boot_fsm.sv
module sdram_boot_fsm
  import sdram_boot_pkg::*;
#(
  parameter int W     = 8,
  parameter int P_CYC = 2,
  parameter int GP    = 2,
  parameter int GC    = 2,
  parameter int GR    = 2,
  parameter int NREF  = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         expired,
  output logic         load,
  output logic [W-1:0] load_val,
  output boot_cmd_e    cmd,
  output logic         in_pause,
  output logic         ready
);

  localparam int RW = $clog2(NREF + 1);

  typedef enum logic [2:0] {
    ST_PAUSE, ST_PRE, ST_WAIT_RP, ST_REF, ST_WAIT_RC, ST_MRS, ST_WAIT_RSC, ST_READY
  } st_e;

  st_e          st, st_nx;
  logic [RW-1:0] ref_cnt;
  logic         ref_done;

  // named events for checking
  logic pre_issue, ref_issue, mrs_issue;
  assign pre_issue = (st == ST_PRE);
  assign ref_issue = (st == ST_REF);
  assign mrs_issue = (st == ST_MRS);
  assign ref_done  = (ref_cnt == RW'(NREF));

  always_comb begin
    st_nx    = st;
    load     = 1'b0;
    load_val = '0;
    unique case (st)
      ST_PAUSE:    if (expired) st_nx = ST_PRE;
      ST_PRE:      begin st_nx = ST_WAIT_RP;  load = 1'b1; load_val = W'(GP - 2); end
      ST_WAIT_RP:  if (expired) st_nx = ST_REF;
      ST_REF:      begin st_nx = ST_WAIT_RC;  load = 1'b1; load_val = W'(GC - 2); end
      ST_WAIT_RC:  if (expired) st_nx = ref_done ? ST_MRS : ST_REF;
      ST_MRS:      begin st_nx = ST_WAIT_RSC; load = 1'b1; load_val = W'(GR - 2); end
      ST_WAIT_RSC: if (expired) st_nx = ST_READY;
      ST_READY:    st_nx = ST_READY;
      default:     st_nx = ST_PAUSE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_PAUSE;
      ref_cnt <= '0;
    end else begin
      st <= st_nx;
      if (ref_issue) ref_cnt <= ref_cnt + RW'(1);
    end
  end

  always_comb begin
    unique case (st)
      ST_PRE:  cmd = CMD_PRE;
      ST_REF:  cmd = CMD_REF;
      ST_MRS:  cmd = CMD_MRS;
      default: cmd = CMD_NOP;
    endcase
  end

  assign in_pause = (st == ST_PAUSE);
  assign ready    = (st == ST_READY);

  // checker-side tallies, independent of the sequencing state
  int unsigned chk_age, chk_refs, chk_since_mrs;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_age       <= 0;
      chk_refs      <= 0;
      chk_since_mrs <= 0;
    end else begin
      if (chk_age < 32'hFFFF_0000) chk_age <= chk_age + 1;
      if (ref_issue) chk_refs <= chk_refs + 1;
      if (mrs_issue) chk_since_mrs <= 1;
      else if (chk_since_mrs != 0 && chk_since_mrs < 32'hFFFF_0000)
        chk_since_mrs <= chk_since_mrs + 1;
    end
  end

  // R3
  pre_after_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_issue |-> (chk_age == P_CYC));
  // R5
  ref_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_issue |-> (chk_refs == NREF));
  // R7
  rsc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (chk_since_mrs == GR));
  // R8
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

endmodule

// File: rtl/sdram_boot_pins.sv
module sdram_boot_pins
  import sdram_boot_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2,
  parameter int DQM_W  = 2
) (
  input  boot_cmd_e           cmd,
  input  logic                ready,
  input  logic [2:0]          burst,
  input  logic                inter,
  input  logic                cas3,
  output logic                cke,
  output logic                cs_n,
  output logic                ras_n,
  output logic                cas_n,
  output logic                we_n,
  output logic [BANK_W-1:0]   ba,
  output logic [ADDR_W-1:0]   addr,
  output logic [DQM_W-1:0]    dqm
);

  localparam logic [ADDR_W-1:0] A10_ONLY = ADDR_W'(1) << 10;

  logic [ADDR_W-1:0] mode_bus;
  assign mode_bus = {{(ADDR_W-10){1'b0}}, mode_word(burst, inter, cas3)};

  always_comb begin
    {cs_n, ras_n, cas_n, we_n} = 4'b0111;
    addr = '0;
    unique case (cmd)
      CMD_PRE: begin {cs_n, ras_n, cas_n, we_n} = 4'b0010; addr = A10_ONLY; end
      CMD_REF: {cs_n, ras_n, cas_n, we_n} = 4'b0001;
      CMD_MRS: begin {cs_n, ras_n, cas_n, we_n} = 4'b0000; addr = mode_bus; end
      default: ;
    endcase
  end

  assign ba  = '0;
  assign cke = 1'b1;
  assign dqm = ready ? '0 : '1;

endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
  import sdram_boot_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 7000,
  parameter int PAUSE_NS      = 200000,
  parameter int TRP_NS        = 20,
  parameter int TRC_NS        = 63,
  parameter int TRSC_CYC      = 2,
  parameter int REF_COUNT     = 8,
  parameter int ADDR_W        = 12,
  parameter int BANK_W        = 2,
  parameter int DQM_W         = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_burst_code,
  input  logic              cfg_interleave,
  input  logic              cfg_cas3,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [DQM_W-1:0]  sd_dqm,
  output logic              init_done
);

  localparam int P_RAW = ns_to_cycles(PAUSE_NS, CLK_PERIOD_PS);
  localparam int P_CYC = (P_RAW < 1) ? 1 : P_RAW;
  localparam int GP    = gap_cycles(ns_to_cycles(TRP_NS, CLK_PERIOD_PS));
  localparam int GC    = gap_cycles(ns_to_cycles(TRC_NS, CLK_PERIOD_PS));
  localparam int GR    = gap_cycles(TRSC_CYC);
  localparam int M1    = (P_CYC > GP) ? P_CYC : GP;
  localparam int M2    = (GC > GR) ? GC : GR;
  localparam int TMAX  = (M1 > M2) ? M1 : M2;
  localparam int TW    = $clog2(TMAX + 1);

  logic          t_load, t_expired, in_pause;
  logic [TW-1:0] t_val;
  boot_cmd_e     cmd;

  sdram_boot_timer #(.W(TW), .RST_VAL(P_CYC - 1)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_expired)
  );

  sdram_boot_fsm #(
    .W(TW), .P_CYC(P_CYC), .GP(GP), .GC(GC), .GR(GR), .NREF(REF_COUNT)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .expired(t_expired), .load(t_load), .load_val(t_val),
    .cmd(cmd), .in_pause(in_pause), .ready(init_done)
  );

  sdram_boot_pins #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .DQM_W(DQM_W)) u_pins (
    .cmd(cmd), .ready(init_done), .burst(cfg_burst_code), .inter(cfg_interleave),
    .cas3(cfg_cas3), .cke(sd_cke), .cs_n(sd_cs_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n),
    .we_n(sd_we_n), .ba(sd_ba), .addr(sd_addr), .dqm(sd_dqm)
  );

  // R2
  pause_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_pause |-> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111
                  && sd_cke && (&sd_dqm)));
  // R3
  pre_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE) |-> (sd_addr[10] && !sd_we_n));
  // R8
  idle_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111
                   && sd_dqm == '0 && sd_cke));

endmodule

// File: tb/sim_sdram_boot_seq.sv
module sim_sdram_boot_seq;

  localparam int PERIOD  = 10;
  localparam int HALF    = PERIOD / 2;
  localparam int PAUSE_N = 1500;
  localparam int TRP_N   = 25;
  localparam int TRC_N   = 65;
  localparam int TRSC    = 2;
  localparam int NREF    = 8;

  function automatic int b_ceil(input int num, input int den);
    int q;
    q = num / den;
    if (q * den < num) q = q + 1;
    return q;
  endfunction
  function automatic int b_floor2(input int v);
    return (v >= 2) ? v : 2;
  endfunction

  localparam int EP     = b_ceil(PAUSE_N * 1000, PERIOD * 1000);
  localparam int EGP    = b_floor2(b_ceil(TRP_N * 1000, PERIOD * 1000));
  localparam int EGC    = b_floor2(b_ceil(TRC_N * 1000, PERIOD * 1000));
  localparam int EGR    = b_floor2(TRSC);
  localparam int J_PRE  = EP;
  localparam int J_REF0 = EP + EGP;
  localparam int J_MRS  = J_REF0 + NREF * EGC;
  localparam int J_RDY  = J_MRS + EGR;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cfg_b = '0;
  logic cfg_i = 1'b0, cfg_c = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, rdy;
  logic [1:0] ba, dqm;
  logic [11:0] addr;

  always #HALF clk = ~clk;

  sdram_boot_seq #(
    .CLK_PERIOD_PS(PERIOD * 1000), .PAUSE_NS(PAUSE_N), .TRP_NS(TRP_N), .TRC_NS(TRC_N),
    .TRSC_CYC(TRSC), .REF_COUNT(NREF), .ADDR_W(12), .BANK_W(2), .DQM_W(2)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_burst_code(cfg_b), .cfg_interleave(cfg_i),
    .cfg_cas3(cfg_c), .sd_cke(cke), .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n),
    .sd_we_n(we_n), .sd_ba(ba), .sd_addr(addr), .sd_dqm(dqm), .init_done(rdy)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] e_cmd(input int j);
    if (j == J_PRE) return 4'b0010;
    if (j >= J_REF0 && j < J_MRS && ((j - J_REF0) % EGC) == 0) return 4'b0001;
    if (j == J_MRS) return 4'b0000;
    return 4'b0111;
  endfunction

  function automatic logic [11:0] e_addr(input int j, input logic [2:0] b, input logic i, input logic c);
    if (j == J_PRE) return 12'h400;
    if (j == J_MRS) return {5'b0, (c ? 3'b011 : 3'b010), i, b};
    return 12'h000;
  endfunction

  function automatic string tag(input int j);
    if (j == 0) return "R1";
    if (j < J_PRE) return "R2";
    if (j == J_PRE) return "R3";
    if (j <= J_REF0) return "R4";
    if (j < J_MRS) return "R5";
    if (j == J_MRS) return "R6";
    if (j <= J_RDY) return "R7";
    return "R8";
  endfunction

  task automatic sample(input int j, input logic [2:0] b, input logic i, input logic c);
    string t;
    t = tag(j);
    check(t, "cmd", {cs_n, ras_n, cas_n, we_n}, e_cmd(j));
    check((j == J_MRS) ? "R6" : ((j == J_PRE) ? "R3" : "R10"), "addr", addr, e_addr(j, b, i, c));
    check(t, "ba", ba, 0);
    check(t, "cke", cke, 1);
    check(t, "dqm", dqm, (j >= J_RDY) ? 0 : 3);
    check(t, "ready", rdy, (j >= J_RDY) ? 1 : 0);
  endtask

  task automatic scramble();
    cfg_b = 3'($urandom);
    cfg_i = 1'($urandom);
    cfg_c = 1'($urandom);
  endtask

  // enters and leaves at a point just after a falling edge
  task automatic do_reset(input string req);
    rst_n = 1'b0;
    scramble();
    repeat (3) @(posedge clk);
    #HALF;
    #1;
    check(req, "rst cmd", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    check(req, "rst ready", rdy, 0);
    check(req, "rst dqm", dqm, 3);
    check(req, "rst cke", cke, 1);
    check(req, "rst addr", addr, 0);
  endtask

  task automatic run_seq(input int stop_at, input logic [2:0] b, input logic i, input logic c);
    rst_n = 1'b1;
    scramble();
    #0;
    sample(0, b, i, c);
    for (int j = 1; j <= J_RDY + 5; j++) begin
      @(posedge clk);
      #(HALF - 1);
      if (j == J_MRS) begin cfg_b = b; cfg_i = i; cfg_c = c; end
      else scramble();
      #1;
      sample(j, b, i, c);
      if (j == stop_at) begin
        rst_n = 1'b0;
        break;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    #1;
    do_reset("R1");
    run_seq(-1, 3'b011, 1'b0, 1'b1);
    do_reset("R9");
    run_seq(-1, 3'b111, 1'b1, 1'b0);
    for (int r = 0; r < 4; r++) begin
      do_reset("R9");
      run_seq(-1, 3'($urandom), 1'($urandom), 1'($urandom));
    end
    do_reset("R9");
    run_seq(int'($urandom_range(J_RDY + 2, J_PRE)), 3'b010, 1'b1, 1'b1);
    do_reset("R9");
    run_seq(J_MRS, 3'b001, 1'b0, 1'b0);
    do_reset("R9");
    run_seq(-1, 3'b101, 1'b1, 1'b1);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule